// File: doc/BRIEF.md
# Ones-Complement Accumulator Execute Unit

This unit is the execute stage of a 16-bit single-accumulator machine. Each instruction reaches it as one stream item: a 5-bit operation code, an 11-bit address field and the memory word already read for that address. The unit updates its accumulator (AC) and its B register (BR), and returns one result item. That item carries the store data with a write strobe, a next-PC selection, the address field as a jump target, and a flag for operations it does not implement. All arithmetic is ones complement with end-around carry. A signed overflow latches an alarm, and by default the alarm stops the machine.

Both sides are valid/ready streams. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears in the next cycle and stays unchanged until the edge where `out_valid` and `out_ready` are both high. `in_ready` is low while a result waits with `out_ready` low, and it also stays low while the machine is halted. The unit therefore never holds more than one result. Bit 15 of every vector is the sign bit, which the machine's own big-endian numbering calls bit 0. The memory side performs the actual write with `out_wr_data` when `out_wr_en` is set. `out_pc_sel` encodes the next PC as follows: 0 = PC+1, 1 = PC+2, 2 = jump to `out_target`.

Top module: `oc_exec_unit`

## Requirements
- R1: An accepted instruction gives exactly one result in the following cycle. While `out_valid` is high and `out_ready` is low, every result field holds its value and `in_ready` is low.
- R2: Opcode 9 adds the memory word to AC. The carry out of bit 15 is added back into bit 0 (for example, 0x0005 + 0xFFFD = 0x0003).
- R3: Opcode 8 loads AC with the memory word. Opcode 10 loads AC with the memory word inverted. Opcode 11 adds the inverted memory word to AC with end-around carry.
- R4: Opcode 12 replaces AC with the bitwise AND of AC and the memory word.
- R5: An add or subtract overflows when both operands have the same sign bit and the sign of the result differs from it. AC still takes the result. `ovf_alarm` rises with that result and stays high until reset. With OVF_HALTS=1, `halt` rises with it as well.
- R6: Opcode 4 sets `out_wr_en` with `out_wr_data` equal to AC. Opcode 6 sets `out_wr_en` with `out_wr_data` = {memory word bits 15:11, AC bits 10:0}. No other opcode sets `out_wr_en`.
- R7: Opcode 15 copies the old AC into BR, then subtracts the memory word from AC as opcode 11 does.
- R8: Opcode 16 always selects 2 (jump). Opcode 18 selects 2 when AC bit 15 is 1, which includes 0xFFFF. Opcode 22 selects 2 when `ovf_alarm` was already set. In every other case these opcodes select 0. `out_target` always equals the address field.
- R9: Opcode 3 selects 1 (skip) when AC differs bitwise from the memory word, and 0 otherwise. This means 0x0000 and 0xFFFF count as different.
- R10: Opcode 0 gives a result with selection 0 and raises `halt`. After that, `in_ready` stays low until reset and no further result appears.
- R11: Opcode 1 (multiply) gives a result with `out_unsup` set and leaves AC and BR unchanged. Every opcode not named in R2 to R10 gives `out_unsup` low, selection 0, no write, and leaves AC and BR unchanged.
- R12: After reset, AC = 0, BR = 0, `out_valid` = 0, `halt` = 0, `ovf_alarm` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction item valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_opcode | input | 5 | Operation code |
| in_addr | input | 11 | Address field |
| in_mem_rdata | input | 16 | Memory word at the address field |
| out_ready | input | 1 | Consumer accepts the result |
| out_valid | output | 1 | Result item valid |
| out_wr_en | output | 1 | Memory write strobe of the result |
| out_wr_data | output | 16 | Word to write back |
| out_pc_sel | output | 2 | 0 = PC+1, 1 = PC+2, 2 = jump |
| out_target | output | 11 | Jump target (the address field) |
| out_unsup | output | 1 | Operation not implemented |
| out_acc | output | 16 | AC after the instruction |
| out_breg | output | 16 | BR after the instruction |
| halt | output | 1 | Machine stopped |
| ovf_alarm | output | 1 | Overflow alarm, latched |

## Verification
The adder is exercised with several operand pairs. A positive plus a negative operand produces a carry, so end-around carry is tested. Two equal values are subtracted to give negative zero. Equal-sign operands are chosen so they overflow, once through add and once through subtract. These cases separate a plain two's-complement adder and a wrong overflow rule from the intended behaviour. The conditional transfers and the identity check are each run with operands that take the condition and with operands that do not. The negative-zero values catch a sign test or comparison that treats 0xFFFF as zero. The consumer drops `out_ready` in a repeating pattern, so results are checked both when they flow through and when they are held under back-pressure.

// File: rtl/oc_exec_pkg.sv
package oc_exec_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_STOP  = 5'd0,
    OP_MPY   = 5'd1,
    OP_CMP   = 5'd3,
    OP_STORE = 5'd4,
    OP_STLO  = 5'd6,
    OP_LOAD  = 5'd8,
    OP_ADD   = 5'd9,
    OP_LOADN = 5'd10,
    OP_SUB   = 5'd11,
    OP_AND   = 5'd12,
    OP_SUBM  = 5'd15,
    OP_JMP   = 5'd16,
    OP_JNEG  = 5'd18,
    OP_JOVF  = 5'd22
  } op_e;

  typedef enum logic [2:0] {
    ALU_KEEP, ALU_LOAD, ALU_LOADN, ALU_ADD, ALU_SUB, ALU_AND
  } alu_e;

  typedef enum logic [1:0] {
    WR_NONE, WR_FULL, WR_LOW
  } wr_e;

  typedef enum logic [2:0] {
    BR_NONE, BR_ALWAYS, BR_NEG, BR_OVF, BR_NEQ
  } br_e;

  typedef enum logic [1:0] {
    PC_NEXT = 2'd0,
    PC_SKIP = 2'd1,
    PC_JUMP = 2'd2
  } pc_e;

  typedef struct packed {
    alu_e alu;
    logic arith;
    wr_e  wr;
    br_e  br;
    logic ld_br;
    logic stop;
    logic unsup;
  } ctrl_t;

endpackage

// File: rtl/oc_decode.sv
module oc_decode
  import oc_exec_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctrl
);

  always_comb begin
    ctrl = '{alu: ALU_KEEP, arith: 1'b0, wr: WR_NONE, br: BR_NONE,
             ld_br: 1'b0, stop: 1'b0, unsup: 1'b0};
    case (opcode)
      OP_STOP:  ctrl.stop  = 1'b1;
      OP_MPY:   ctrl.unsup = 1'b1;
      OP_CMP:   ctrl.br    = BR_NEQ;
      OP_STORE: ctrl.wr    = WR_FULL;
      OP_STLO:  ctrl.wr    = WR_LOW;
      OP_LOAD:  ctrl.alu   = ALU_LOAD;
      OP_LOADN: ctrl.alu   = ALU_LOADN;
      OP_AND:   ctrl.alu   = ALU_AND;
      OP_ADD: begin
        ctrl.alu   = ALU_ADD;
        ctrl.arith = 1'b1;
      end
      OP_SUB: begin
        ctrl.alu   = ALU_SUB;
        ctrl.arith = 1'b1;
      end
      OP_SUBM: begin
        ctrl.alu   = ALU_SUB;
        ctrl.arith = 1'b1;
        ctrl.ld_br = 1'b1;
      end
      OP_JMP:   ctrl.br = BR_ALWAYS;
      OP_JNEG:  ctrl.br = BR_NEG;
      OP_JOVF:  ctrl.br = BR_OVF;
      default: ;
    endcase
  end

endmodule

// File: rtl/oc_adder.sv
module oc_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         ovf
);

  localparam int MSB = W - 1;

  logic [W:0] raw;

  assign raw = {1'b0, a} + {1'b0, b};
  // End-around carry: the carry out re-enters at the least significant bit.
  assign sum = raw[MSB:0] + {{MSB{1'b0}}, raw[W]};
  assign ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/oc_branch.sv
module oc_branch
  import oc_exec_pkg::*;
(
  input  br_e  cond,
  input  logic acc_neg,
  input  logic alarm,
  input  logic neq,
  output pc_e  sel
);

  always_comb begin
    sel = PC_NEXT;
    case (cond)
      BR_ALWAYS: sel = PC_JUMP;
      BR_NEG:    sel = acc_neg ? PC_JUMP : PC_NEXT;
      BR_OVF:    sel = alarm   ? PC_JUMP : PC_NEXT;
      BR_NEQ:    sel = neq     ? PC_SKIP : PC_NEXT;
      default:   sel = PC_NEXT;
    endcase
  end

endmodule

// File: rtl/oc_exec_unit.sv
module oc_exec_unit
  import oc_exec_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 11,
  parameter bit OVF_HALTS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_opcode,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_mem_rdata,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_wr_en,
  output logic [DATA_W-1:0] out_wr_data,
  output logic [1:0]        out_pc_sel,
  output logic [ADDR_W-1:0] out_target,
  output logic              out_unsup,
  output logic [DATA_W-1:0] out_acc,
  output logic [DATA_W-1:0] out_breg,
  output logic              halt,
  output logic              ovf_alarm
);

  localparam int MSB = DATA_W - 1;
  localparam int KEEP_W = DATA_W - ADDR_W;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] acc_q, br_q, acc_d;
  logic [DATA_W-1:0] add_b, add_sum;
  logic              add_ovf;
  logic              halted_q, alarm_q;
  logic              fire;
  pc_e               pc_d;
  logic [DATA_W-1:0] wr_data_d;

  logic              rv_q, wen_q, uns_q;
  logic [DATA_W-1:0] wd_q;
  pc_e               pc_q;
  logic [ADDR_W-1:0] tgt_q;

  oc_decode u_dec (
    .opcode (in_opcode),
    .ctrl   (ctrl)
  );

  assign add_b = (ctrl.alu == ALU_SUB) ? ~in_mem_rdata : in_mem_rdata;

  oc_adder #(.W(DATA_W)) u_add (
    .a   (acc_q),
    .b   (add_b),
    .sum (add_sum),
    .ovf (add_ovf)
  );

  oc_branch u_br (
    .cond    (ctrl.br),
    .acc_neg (acc_q[MSB]),
    .alarm   (alarm_q),
    .neq     (acc_q != in_mem_rdata),
    .sel     (pc_d)
  );

  always_comb begin
    acc_d = acc_q;
    case (ctrl.alu)
      ALU_LOAD:         acc_d = in_mem_rdata;
      ALU_LOADN:        acc_d = ~in_mem_rdata;
      ALU_ADD, ALU_SUB: acc_d = add_sum;
      ALU_AND:          acc_d = acc_q & in_mem_rdata;
      default: ;
    endcase
  end

  always_comb begin
    wr_data_d = '0;
    case (ctrl.wr)
      WR_FULL: wr_data_d = acc_q;
      WR_LOW:  wr_data_d = {in_mem_rdata[MSB -: KEEP_W], acc_q[ADDR_W-1:0]};
      default: ;
    endcase
  end

  generate
    if (OVF_HALTS) begin : g_alarm_stops
      assign halt = halted_q | alarm_q;
    end else begin : g_alarm_flag_only
      assign halt = halted_q;
    end
  endgenerate

  assign in_ready = !halt && (!rv_q || out_ready);
  assign fire     = in_valid && in_ready;

  // Architectural state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      br_q     <= '0;
      halted_q <= 1'b0;
      alarm_q  <= 1'b0;
    end else if (fire) begin
      acc_q <= acc_d;
      if (ctrl.ld_br) br_q <= acc_q;
      if (ctrl.stop) halted_q <= 1'b1;
      if (ctrl.arith && add_ovf) alarm_q <= 1'b1;
    end
  end

  // Result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      wen_q <= 1'b0;
      wd_q  <= '0;
      pc_q  <= PC_NEXT;
      tgt_q <= '0;
      uns_q <= 1'b0;
    end else if (fire) begin
      rv_q  <= 1'b1;
      wen_q <= (ctrl.wr != WR_NONE);
      wd_q  <= wr_data_d;
      pc_q  <= pc_d;
      tgt_q <= in_addr;
      uns_q <= ctrl.unsup;
    end else if (out_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign out_valid   = rv_q;
  assign out_wr_en   = wen_q;
  assign out_wr_data = wd_q;
  assign out_pc_sel  = pc_q;
  assign out_target  = tgt_q;
  assign out_unsup   = uns_q;
  assign out_acc     = acc_q;
  assign out_breg    = br_q;
  assign ovf_alarm   = alarm_q;

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_wr_data) &&
    $stable(out_pc_sel) && $stable(out_acc) && $stable(out_breg));

  // R5
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_alarm |=> ovf_alarm);

  // R5
  alarm_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_alarm) |-> out_valid);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(out_acc) && $stable(out_breg));

  // R6
  store_no_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr_en |-> out_pc_sel == PC_NEXT);

  // R8
  pc_sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pc_sel != 2'd3);

  // R11
  unsup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unsup |-> !out_wr_en && out_pc_sel == PC_NEXT);

endmodule

// File: tb/oc_exec_unit_tb_top.sv
`timescale 1ns/1ps
module oc_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_opcode = '0;
  logic [10:0] in_addr = '0;
  logic [15:0] in_mem_rdata = '0;
  logic        out_ready = 1'b1;
  logic        out_valid, out_wr_en, out_unsup, halt, ovf_alarm;
  logic [15:0] out_wr_data, out_acc, out_breg;
  logic [1:0]  out_pc_sel;
  logic [10:0] out_target;

  // second instance: alarm does not stop the machine
  logic        nh_valid = 1'b0;
  logic        nh_ready;
  logic [4:0]  nh_op = '0;
  logic [10:0] nh_addr = '0;
  logic [15:0] nh_m = '0;
  logic        nh_ov, nh_wen, nh_uns, nh_halt, nh_alarm;
  logic [15:0] nh_wd, nh_acc, nh_br;
  logic [1:0]  nh_pc;
  logic [10:0] nh_tgt;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oc_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_opcode(in_opcode),
    .in_addr(in_addr), .in_mem_rdata(in_mem_rdata),
    .out_ready(out_ready), .out_valid(out_valid), .out_wr_en(out_wr_en),
    .out_wr_data(out_wr_data), .out_pc_sel(out_pc_sel), .out_target(out_target),
    .out_unsup(out_unsup), .out_acc(out_acc), .out_breg(out_breg),
    .halt(halt), .ovf_alarm(ovf_alarm)
  );

  oc_exec_unit #(.OVF_HALTS(1'b0)) dut_nh (
    .clk(clk), .rst_n(rst_n),
    .in_valid(nh_valid), .in_ready(nh_ready), .in_opcode(nh_op),
    .in_addr(nh_addr), .in_mem_rdata(nh_m),
    .out_ready(1'b1), .out_valid(nh_ov), .out_wr_en(nh_wen),
    .out_wr_data(nh_wd), .out_pc_sel(nh_pc), .out_target(nh_tgt),
    .out_unsup(nh_uns), .out_acc(nh_acc), .out_breg(nh_br),
    .halt(nh_halt), .ovf_alarm(nh_alarm)
  );

  typedef struct {
    logic        wen;
    logic [15:0] wd;
    logic [1:0]  pc;
    logic [10:0] tgt;
    logic        uns;
    logic [15:0] acc;
    logic [15:0] br;
    string       tag;
  } exp_t;

  exp_t q[$];

  logic [15:0] m_acc, m_br;
  logic        m_alarm, m_halt;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [16:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] raw;
    logic [15:0] s;
    raw = {1'b0, a} + {1'b0, b};
    s = raw[15:0] + {15'd0, raw[16]};
    return {(a[15] == b[15]) && (s[15] != a[15]), s};
  endfunction

  function automatic exp_t model(input logic [4:0] op, input logic [10:0] a,
                                 input logic [15:0] m);
    exp_t e;
    logic [16:0] r;
    e.wen = 1'b0; e.wd = '0; e.pc = 2'd0; e.tgt = a; e.uns = 1'b0;
    r = '0;
    case (op)
      5'd0:  m_halt = 1'b1;
      5'd1:  e.uns = 1'b1;
      5'd3:  e.pc = (m_acc != m) ? 2'd1 : 2'd0;
      5'd4:  begin e.wen = 1'b1; e.wd = m_acc; end
      5'd6:  begin e.wen = 1'b1; e.wd = {m[15:11], m_acc[10:0]}; end
      5'd8:  m_acc = m;
      5'd9:  begin r = oc_add(m_acc, m); m_acc = r[15:0]; end
      5'd10: m_acc = ~m;
      5'd11: begin r = oc_add(m_acc, ~m); m_acc = r[15:0]; end
      5'd12: m_acc = m_acc & m;
      5'd15: begin m_br = m_acc; r = oc_add(m_acc, ~m); m_acc = r[15:0]; end
      5'd16: e.pc = 2'd2;
      5'd18: e.pc = m_acc[15] ? 2'd2 : 2'd0;
      5'd22: e.pc = m_alarm ? 2'd2 : 2'd0;
      default: ;
    endcase
    if (r[16]) begin m_alarm = 1'b1; m_halt = 1'b1; end
    e.acc = m_acc;
    e.br  = m_br;
    return e;
  endfunction

  task automatic send(input logic [4:0] op, input logic [10:0] a,
                      input logic [15:0] m, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_addr = a; in_mem_rdata = m;
    while (!in_ready) @(negedge clk);
    e = model(op, a, m);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && q.size() != 0; i++) @(negedge clk);
    chk(q.size() == 0, "R1", "results drained", q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0; nh_valid = 1'b0;
    rst_n = 1'b0;
    m_acc = '0; m_br = '0; m_alarm = 1'b0; m_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_stopped(input string req);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = 5'd8; in_addr = '0; in_mem_rdata = 16'h1111;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!in_ready, req, "in_ready low while halted", in_ready, 0);
      chk(!out_valid, req, "no result while halted", out_valid, 0);
    end
    in_valid = 1'b0;
    chk(out_acc == m_acc, req, "AC frozen while halted", out_acc, m_acc);
  endtask

  // consumer back-pressure pattern, changed away from both edges
  always @(posedge clk) begin
    #1;
    out_ready = ((cyc % 5) != 3) && ((cyc % 7) != 2);
    cyc = cyc + 1;
  end

  // monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic [15:0] prev_wd, prev_acc;
  logic [1:0]  prev_pc;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid && out_wr_data == prev_wd && out_pc_sel == prev_pc &&
            out_acc == prev_acc, "R1", "result held under stall",
            {out_acc, out_wr_data}, {prev_acc, prev_wd});
      end
      if (out_valid && !out_ready)
        chk(!in_ready, "R1", "in_ready low under stall", in_ready, 0);
      prev_stall = out_valid && !out_ready;
      prev_wd = out_wr_data; prev_pc = out_pc_sel; prev_acc = out_acc;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_wr_en == e.wen, e.tag, "wr_en", out_wr_en, e.wen);
          if (e.wen) chk(out_wr_data == e.wd, e.tag, "wr_data", out_wr_data, e.wd);
          chk(out_pc_sel == e.pc, e.tag, "pc_sel", out_pc_sel, e.pc);
          chk(out_target == e.tgt, e.tag, "target", out_target, e.tgt);
          chk(out_unsup == e.uns, e.tag, "unsup", out_unsup, e.uns);
          chk(out_acc == e.acc, e.tag, "acc", out_acc, e.acc);
          chk(out_breg == e.br, e.tag, "breg", out_breg, e.br);
        end
      end
    end else begin
      prev_stall = 1'b0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12 reset state
    chk(in_ready == 1'b1, "R12", "in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R12", "out_valid", out_valid, 0);
    chk(halt == 1'b0 && ovf_alarm == 1'b0, "R12", "halt/alarm", {halt, ovf_alarm}, 0);
    chk(out_acc == 16'h0 && out_breg == 16'h0, "R12", "AC/BR", {out_acc, out_breg}, 0);

    send(5'd8,  11'h001, 16'h0005, "R3 load");
    send(5'd9,  11'h002, 16'hFFFD, "R2 add end-around");
    send(5'd9,  11'h003, 16'h0010, "R2 add no carry");
    send(5'd11, 11'h004, 16'h0013, "R3 sub to negative zero");
    send(5'd18, 11'h055, 16'h0000, "R8 jneg on -0");
    send(5'd10, 11'h005, 16'h1234, "R3 load negated");
    send(5'd18, 11'h0AA, 16'h0000, "R8 jneg taken");
    send(5'd8,  11'h006, 16'h0100, "R3 load");
    send(5'd18, 11'h0AB, 16'h0000, "R8 jneg not taken");
    send(5'd22, 11'h200, 16'h0000, "R8 jovf not taken");
    send(5'd16, 11'h7FF, 16'h0000, "R8 jump");
    send(5'd8,  11'h007, 16'h3C5A, "R3 load");
    send(5'd12, 11'h008, 16'h0FF0, "R4 and");
    send(5'd4,  11'h00A, 16'hAAAA, "R6 full store");
    send(5'd6,  11'h00B, 16'hABCD, "R6 low store");
    send(5'd3,  11'h00C, 16'h0C50, "R9 equal");
    send(5'd3,  11'h00D, 16'h0C51, "R9 unequal");
    send(5'd8,  11'h00E, 16'h0000, "R3 load zero");
    send(5'd3,  11'h00F, 16'hFFFF, "R9 +0 vs -0");
    send(5'd8,  11'h010, 16'h0040, "R3 load");
    send(5'd15, 11'h011, 16'h0010, "R7 sub magnitudes");
    send(5'd1,  11'h012, 16'h7777, "R11 multiply");
    send(5'd2,  11'h013, 16'h5555, "R11 out-of-scope no-op");
    send(5'd8,  11'h014, 16'h7000, "R3 load");
    send(5'd9,  11'h015, 16'h7000, "R5 add overflow");
    drain();
    chk(ovf_alarm == 1'b1, "R5", "alarm latched", ovf_alarm, 1);
    chk(halt == 1'b1, "R5", "halt on alarm", halt, 1);
    check_stopped("R5");

    do_reset();
    send(5'd8,  11'h020, 16'h8000, "R3 load");
    send(5'd11, 11'h021, 16'h7FFF, "R5 sub overflow");
    drain();
    chk(ovf_alarm == 1'b1 && halt == 1'b1, "R5", "sub alarm", {halt, ovf_alarm}, 3);

    do_reset();
    chk(ovf_alarm == 1'b0, "R5", "alarm cleared by reset", ovf_alarm, 0);
    send(5'd8, 11'h030, 16'h0123, "R3 load");
    send(5'd0, 11'h031, 16'h0000, "R10 halt op");
    drain();
    chk(halt == 1'b1 && ovf_alarm == 1'b0, "R10", "halt without alarm", {halt, ovf_alarm}, 2);
    check_stopped("R10");

    // R5/R8: overflow condition transfer with alarm not stopping the machine
    do_reset();
    @(negedge clk);
    nh_valid = 1'b1; nh_op = 5'd8; nh_m = 16'h7FFF; nh_addr = 11'h001;
    @(negedge clk);
    nh_op = 5'd9; nh_m = 16'h0001;
    @(negedge clk);
    chk(nh_alarm == 1'b1 && nh_halt == 1'b0, "R5", "alarm without stop", {nh_halt, nh_alarm}, 1);
    chk(nh_acc == 16'h8000, "R5", "AC takes overflowed sum", nh_acc, 16'h8000);
    nh_op = 5'd22; nh_addr = 11'h123;
    @(negedge clk);
    nh_valid = 1'b0;
    chk(nh_ov && nh_pc == 2'd2, "R8", "jovf taken", nh_pc, 2);
    chk(nh_tgt == 11'h123, "R8", "jovf target", nh_tgt, 11'h123);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule